// File: doc/BRIEF.md
# Byte and Word ALU with Per-Flag Keep Mask

This block is the purely combinational arithmetic-logic unit of a small 8-bit processor core with a 32-entry register file. Each cycle the core presents an operation code, a 16-bit destination operand (a register or a register pair), an 8-bit source operand (a register or a constant from the instruction), a use-carry control, a keep-flags mask and the current status byte. The block returns a 16-bit result and the status byte to be written back.

Byte operations cover add and subtract, with or without the incoming carry, plus AND, OR and XOR. XOR with use-carry set gives a one's complement with the carry forced. There is a 16-bit copy, a constant pass-through, and word add and word subtract of a 6-bit unsigned immediate on a register pair. One operation sets or clears a single status flag, or moves a bit between a register and the T flag.

The keep-flags mask lets the decoder preserve selected flags. Increment and decrement use it to hold I, T, H and C. Pointer updates use an all-ones mask so that no flag changes.

Top module: `byte_word_alu`

## Requirements
- R1: Operation codes are 0 copy, 1 add, 2 subtract, 3 AND, 4 OR, 5 XOR, 6 constant, 7 word add, 8 word subtract, 9 status-bit. Codes 10 to 15 give result 0 with the status byte unchanged.
- R2: The status byte is ordered from bit 7 down to bit 0 as I, T, H, S, V, N, Z, C. Each status bit whose keep-flags bit is 1 equals the incoming bit. Each status bit whose keep-flags bit is 0 takes the newly computed value.
- R3: Add forms a = rd_in[7:0] plus rr_in plus the incoming C, where C is added only when use_carry is 1. C is the carry out of bit 7, H is the carry out of bit 3, and V is signed overflow. N is result bit 7 and Z is set when the result is zero.
- R4: Subtract forms rd_in[7:0] minus rr_in minus the incoming C, where C is subtracted only when use_carry is 1. C and H are the borrows out of bits 7 and 3, and V is signed overflow. With use_carry 1, Z is set only when the result is zero and the incoming Z was 1; with use_carry 0, Z is set when the result is zero.
- R5: AND, OR and XOR clear V, set N and Z from the result, and keep H. C becomes 1 when use_carry is 1 and is kept otherwise.
- R6: For every byte operation (add, subtract, logic, constant, status-bit), result[15:8] is 0. For add, subtract, the logic operations and both word operations, S equals N XOR V.
- R7: Word add and word subtract combine the 16-bit rd_in with the unsigned value rr_in[5:0]. C is the carry or borrow out of bit 15, and V is signed overflow of the 16-bit result. N is result bit 15, Z is set for a zero result, and I, T and H are kept.
- R8: The copy operation returns all 16 bits of rd_in and leaves the status byte unchanged.
- R9: The constant operation returns {8'h00, rr_in} and leaves the status byte unchanged.
- R10: Status-bit operation with rr_in[3] = 0: the flag at position rr_in[2:0] becomes use_carry. All other flags are kept, and the result is {8'h00, rd_in[7:0]}.
- R11: Status-bit operation with rr_in[3] = 1 and use_carry = 1: T becomes rd_in[rr_in[2:0]]. The other flags are kept, and the result is {8'h00, rd_in[7:0]}.
- R12: Status-bit operation with rr_in[3] = 1 and use_carry = 0: the result is rd_in[7:0] with bit rr_in[2:0] replaced by the incoming T, upper byte 0. The status byte is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code |
| use_carry | input | 1 | Carry-in enable, complement carry set, or bit-operation direction |
| keep_flags | input | 8 | Per-flag mask; a 1 keeps the incoming flag |
| rd_in | input | 16 | Destination operand, a register pair for word and copy operations |
| rr_in | input | 8 | Source operand or constant |
| flags_in | input | 8 | Current status byte |
| result | output | 16 | Computed result |
| flags_out | output | 8 | Next status byte |

## Verification
The immediate checks in the bound checker assume two-state inputs that have settled before the outputs are read. Since the block has no state, each check compares the present outputs with the present inputs. The bench drives every input in one step, waits, and only then compares. It never leaves X values on any port. The sign-rule check runs only when the keep mask leaves S, V and N all computed. The bench sweeps the mask separately, so mask behaviour is tested apart from the arithmetic sweeps.

// File: rtl/byte_word_alu.sv
module byte_word_alu (
  input  logic [3:0]  op,
  input  logic        use_carry,
  input  logic [7:0]  keep_flags,
  input  logic [15:0] rd_in,
  input  logic [7:0]  rr_in,
  input  logic [7:0]  flags_in,
  output logic [15:0] result,
  output logic [7:0]  flags_out
);
  localparam logic [3:0] OP_COPY = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_AND  = 4'd3;
  localparam logic [3:0] OP_OR   = 4'd4;
  localparam logic [3:0] OP_XOR  = 4'd5;
  localparam logic [3:0] OP_CONST= 4'd6;
  localparam logic [3:0] OP_WADD = 4'd7;
  localparam logic [3:0] OP_WSUB = 4'd8;
  localparam logic [3:0] OP_SBIT = 4'd9;

  localparam int FT = 6;
  localparam int FH = 5;
  localparam int FS = 4;
  localparam int FV = 3;
  localparam int FN = 2;
  localparam int FZ = 1;
  localparam int FC = 0;

  wire [7:0] a   = rd_in[7:0];
  wire [7:0] b   = rr_in;
  wire       cin = use_carry & flags_in[FC];

  wire [8:0]  add9 = {1'b0, a} + {1'b0, b} + {8'b0, cin};
  wire [4:0]  addh = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, cin};
  wire [8:0]  sub9 = {1'b0, a} - {1'b0, b} - {8'b0, cin};
  wire [4:0]  subh = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'b0, cin};
  wire [16:0] wsum = {1'b0, rd_in} + {11'b0, b[5:0]};
  wire [16:0] wdif = {1'b0, rd_in} - {11'b0, b[5:0]};
  wire [2:0]  sel  = b[2:0];

  logic [7:0]  fresh;
  logic [15:0] res;
  logic        sign_rule;

  always_comb begin
    fresh     = flags_in;
    res       = 16'h0000;
    sign_rule = 1'b0;
    case (op)
      OP_COPY: res = rd_in;
      OP_ADD: begin
        res       = {8'h00, add9[7:0]};
        fresh[FC] = add9[8];
        fresh[FH] = addh[4];
        fresh[FV] = (a[7] == b[7]) && (add9[7] != a[7]);
        fresh[FN] = add9[7];
        fresh[FZ] = (add9[7:0] == 8'h00);
        sign_rule = 1'b1;
      end
      OP_SUB: begin
        res       = {8'h00, sub9[7:0]};
        fresh[FC] = sub9[8];
        fresh[FH] = subh[4];
        fresh[FV] = (a[7] != b[7]) && (sub9[7] != a[7]);
        fresh[FN] = sub9[7];
        fresh[FZ] = (sub9[7:0] == 8'h00) && (!use_carry || flags_in[FZ]);
        sign_rule = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        if (op == OP_AND)     res = {8'h00, a & b};
        else if (op == OP_OR) res = {8'h00, a | b};
        else                  res = {8'h00, a ^ b};
        fresh[FV] = 1'b0;
        fresh[FN] = res[7];
        fresh[FZ] = (res[7:0] == 8'h00);
        if (use_carry) fresh[FC] = 1'b1;
        sign_rule = 1'b1;
      end
      OP_CONST: res = {8'h00, b};
      OP_WADD: begin
        res       = wsum[15:0];
        fresh[FC] = wsum[16];
        fresh[FV] = !rd_in[15] && wsum[15];
        fresh[FN] = wsum[15];
        fresh[FZ] = (wsum[15:0] == 16'h0000);
        sign_rule = 1'b1;
      end
      OP_WSUB: begin
        res       = wdif[15:0];
        fresh[FC] = wdif[16];
        fresh[FV] = rd_in[15] && !wdif[15];
        fresh[FN] = wdif[15];
        fresh[FZ] = (wdif[15:0] == 16'h0000);
        sign_rule = 1'b1;
      end
      OP_SBIT: begin
        res = {8'h00, a};
        if (!b[3])          fresh[sel] = use_carry;
        else if (use_carry) fresh[FT]  = a[sel];
        else                res[sel]   = flags_in[FT];
      end
      default: ;
    endcase
    if (sign_rule) fresh[FS] = fresh[FN] ^ fresh[FV];
  end

  assign result    = res;
  assign flags_out = (keep_flags & flags_in) | (~keep_flags & fresh);
endmodule

// File: rtl/byte_word_alu_chk.sv
module byte_word_alu_chk (
  input logic [3:0]  op,
  input logic        use_carry,
  input logic [7:0]  keep_flags,
  input logic [15:0] rd_in,
  input logic [7:0]  rr_in,
  input logic [7:0]  flags_in,
  input logic [15:0] result,
  input logic [7:0]  flags_out
);
  wire byte_op  = (op >= 4'd1 && op <= 4'd6) || op == 4'd9;
  wire arith_op = (op >= 4'd1 && op <= 4'd5) || op == 4'd7 || op == 4'd8;

  always_comb begin
    a_r2_keep_mask: assert (((flags_out ^ flags_in) & keep_flags) == 8'h00)
      else $error("kept flag changed");
    a_r6_upper_zero: assert (!byte_op || result[15:8] == 8'h00)
      else $error("byte op upper nonzero");
    a_r6_sign_rule: assert (!arith_op || keep_flags[4:2] != 3'b000 ||
                            flags_out[4] == (flags_out[2] ^ flags_out[3]))
      else $error("S != N^V");
    a_r8_copy: assert (op != 4'd0 || (result == rd_in && flags_out == flags_in))
      else $error("copy mismatch");
    a_r9_const: assert (op != 4'd6 || (result == {8'h00, rr_in} && flags_out == flags_in))
      else $error("constant mismatch");
    a_r1_reserved: assert (op < 4'd10 || (result == 16'h0000 && flags_out == flags_in))
      else $error("reserved op active");
    a_r7_word_keeps_h: assert (!(op == 4'd7 || op == 4'd8) || flags_out[7:5] == flags_in[7:5])
      else $error("word op touched I/T/H");
    a_r12_one_bit: assert (!(op == 4'd9 && rr_in[3] && !use_carry) ||
                           ($onehot0(result[7:0] ^ rd_in[7:0]) && flags_out == flags_in))
      else $error("T load changed more than one bit");
  end
endmodule

bind byte_word_alu byte_word_alu_chk chk_i (.*);

// File: tb/byte_word_alu_tb_top.sv
`timescale 1ns/1ps
module byte_word_alu_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [3:0]  op;
  logic        use_carry;
  logic [7:0]  keep_flags;
  logic [15:0] rd_in;
  logic [7:0]  rr_in;
  logic [7:0]  flags_in;
  logic [15:0] result;
  logic [7:0]  flags_out;

  byte_word_alu dut_i (
    .op(op), .use_carry(use_carry), .keep_flags(keep_flags), .rd_in(rd_in),
    .rr_in(rr_in), .flags_in(flags_in), .result(result), .flags_out(flags_out)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int sx8(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic logic [23:0] model(input int o, input int uc, input logic [7:0] keep,
                                        input logic [15:0] rd, input logic [7:0] rr,
                                        input logic [7:0] fi);
    logic [7:0]  f;
    logic [15:0] r;
    int a, b, c, s, h, sv;
    logic [7:0] lr;
    f = fi; r = 16'h0;
    a = int'(rd[7:0]); b = int'(rr);
    c = (uc != 0 && fi[0]) ? 1 : 0;
    case (o)
      0: r = rd;
      1: begin
        s = a + b + c; h = (a % 16) + (b % 16) + c; sv = sx8(a) + sx8(b) + c;
        r = 16'(s % 256);
        f[0] = s > 255; f[5] = h > 15; f[3] = sv > 127 || sv < -128;
        f[2] = r[7]; f[1] = r == 0; f[4] = f[2] ^ f[3];
      end
      2: begin
        s = a - b - c; h = (a % 16) - (b % 16) - c; sv = sx8(a) - sx8(b) - c;
        r = 16'((s + 512) % 256);
        f[0] = s < 0; f[5] = h < 0; f[3] = sv > 127 || sv < -128;
        f[2] = r[7]; f[1] = (r == 0) && (uc == 0 || fi[1]); f[4] = f[2] ^ f[3];
      end
      3, 4, 5: begin
        lr = (o == 3) ? (rd[7:0] & rr) : (o == 4) ? (rd[7:0] | rr) : (rd[7:0] ^ rr);
        r = {8'h00, lr};
        f[3] = 0; f[2] = lr[7]; f[1] = lr == 0; f[4] = lr[7];
        if (uc != 0) f[0] = 1;
      end
      6: r = {8'h00, rr};
      7, 8: begin
        s = (o == 7) ? int'(rd) + (b % 64) : int'(rd) - (b % 64);
        r = 16'((s + 131072) % 65536);
        f[0] = (o == 7) ? (s > 65535) : (s < 0);
        f[3] = (o == 7) ? (rd < 16'h8000 && r >= 16'h8000) : (rd >= 16'h8000 && r < 16'h8000);
        f[2] = r[15]; f[1] = r == 0; f[4] = f[2] ^ f[3];
      end
      9: begin
        r = {8'h00, rd[7:0]};
        if (rr[3] == 0)   f[rr[2:0]] = (uc != 0);
        else if (uc != 0) f[6] = rd[rr[2:0]];
        else              r[rr[2:0]] = fi[6];
      end
      default: ;
    endcase
    f = (keep & fi) | (~keep & f);
    return {r, f};
  endfunction

  task automatic run(input int o, input int uc, input logic [7:0] keep, input logic [15:0] rd,
                     input logic [7:0] rr, input logic [7:0] fi, input string req);
    logic [23:0] exp;
    op = 4'(o); use_carry = (uc != 0); keep_flags = keep; rd_in = rd; rr_in = rr; flags_in = fi;
    #2;
    exp = model(o, uc, keep, rd, rr, fi);
    checks++;
    if ({result, flags_out} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d uc=%0d rd=%h rr=%h fi=%h: actual %h/%h expected %h/%h",
               req, o, uc, rd, rr, fi, result, flags_out, exp[23:8], exp[7:0]);
    end
  endtask

  initial begin
    op = 0; use_carry = 0; keep_flags = 0; rd_in = 0; rr_in = 0; flags_in = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    checks++;
    if (result !== 16'h0 || flags_out !== 8'h0) begin
      errors++;
      $display("FAIL R8 idle: actual %h/%h expected 0000/00", result, flags_out);
    end
    // R3 R4: exhaustive byte add/subtract, both carry modes
    for (int o = 1; o <= 2; o++)
      for (int uc = 0; uc < 2; uc++)
        for (int a = 0; a < 256; a++)
          for (int b = 0; b < 256; b++)
            run(o, uc, 8'h00, {8'hA5, 8'(a)}, 8'(b), 8'(a) ^ {b[0], 7'(b >> 1)},
                (o == 1) ? "R3" : "R4");
    // R5 R6: exhaustive logic ops
    for (int o = 3; o <= 5; o++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          run(o, b % 2, 8'h00, {8'h3C, 8'(a)}, 8'(b), 8'(b) ^ 8'(a >> 2), "R5");
    // R7: word add/subtract, sweep pairs plus boundaries
    for (int o = 7; o <= 8; o++)
      for (int i = 0; i < 260; i++)
        for (int k = 0; k < 64; k++) begin
          logic [15:0] rd;
          rd = (i == 256) ? 16'h0000 : (i == 257) ? 16'h7FFF :
               (i == 258) ? 16'h8000 : (i == 259) ? 16'hFFFF : 16'(i * 251 + (i << 8));
          run(o, 0, 8'h00, rd, {2'(i), 6'(k)}, 8'(i * 7), "R7");
        end
    // R2: keep mask over add and subtract
    for (int m = 0; m < 256; m++)
      for (int v = 0; v < 8; v++) begin
        run(1 + (v % 2), v / 4, 8'(m), 16'(v * 37 + m), 8'(m ^ (v * 29)), 8'(~m + v), "R2");
      end
    // increment / decrement style masks
    run(1, 0, 8'hE1, 16'h007F, 8'h01, 8'hFF, "R2");
    run(2, 0, 8'hE1, 16'h0080, 8'h01, 8'h00, "R2");
    run(7, 0, 8'hFF, 16'hFFFF, 8'h01, 8'h5A, "R2");
    // R10 R11 R12: status-bit operation
    for (int k = 0; k < 16; k++)
      for (int uc = 0; uc < 2; uc++)
        for (int f = 0; f < 256; f++)
          run(9, uc, 8'h00, {8'hC3, 8'(f * 13 + k)}, {4'hF, 4'(k)}, 8'(f),
              (k < 8) ? "R10" : (uc != 0) ? "R11" : "R12");
    // R8 R9 R1: copy, constant, reserved codes
    for (int i = 0; i < 512; i++) begin
      run(0, i % 2, 8'h00, 16'(i * 129 + 7), 8'(i), 8'(i * 3), "R8");
      run(6, i % 2, 8'h00, 16'(i * 131), 8'(i * 5), 8'(i * 11), "R9");
      run(10 + (i % 6), i % 2, 8'(i), 16'(i * 97 + 1), 8'(i + 3), 8'(~i), "R1");
    end
    // R6: upper byte zero with a nonzero upper destination byte
    run(1, 0, 8'h00, 16'hFFFF, 8'hFF, 8'h00, "R6");
    run(9, 0, 8'h00, 16'hFF00, 8'h0F, 8'h40, "R6");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule